// File: doc/BRIEF.md
# Far Jump Protection Walker

This block decides what a protected-mode far jump may do once the destination selector is known. A request supplies the selector, the target offset, the operand size and the current privilege level. The block then reads the indexed descriptor through a request/acknowledge read port and sorts it into one of five kinds:

- conforming code
- non-conforming code
- call gate
- task gate
- available task state segment

It applies the privilege, presence and limit rules for that kind. For either gate it checks the selector held inside the gate and reads a second descriptor.

Every request ends with a one-cycle `done_o` pulse and one of three results:

- a code-segment load: the new selector with its RPL replaced by the current privilege level, plus the new instruction offset;
- a request to switch tasks without nesting to a given task-state selector;
- a fault, with its vector and error code.

The result stays on the outputs until the next request finishes. The task switch itself is carried out elsewhere.

Descriptors use the usual 8-byte layout:

| Bits | Code and TSS descriptors | Gate descriptors |
|---|---|---|
| 15:0 | limit, low part | offset, low half |
| 31:16 | — | target selector |
| 47:40 | access byte: present bit 47, DPL 46:45, S bit 44, type 43:40 | same |
| 51:48 | limit, high part | offset, high half (63:48) |
| 55 | granularity | — |

Selector fields are index 15:3, table bit 2 (1 = local table) and RPL 1:0.

Top module: `farjmp_guard`

## Requirements
- R1: After reset `done_o`, `busy_o` and `rd_req_o` are low.
- R2: A selector with index 0 and table bit 0 (any RPL) faults with vector 13 and error code 0, and no descriptor is read.
- R3: If `index*8+7` exceeds the limit of the table named by bit 2 (global or local), the jump faults with vector 13 and no read takes place. The error code for this and for every selector-coded fault is the selector with bits 1:0 cleared.
- R4: `rd_req_o` stays high with `rd_sel_o` unchanged until `rd_ack_i` is seen. `rd_desc_i` is taken in the cycle of the acknowledge. `done_o` is high for exactly one cycle per request.
- R5: The kind is decoded from the S bit and the type. S=1 with type bit 3 set is code, and type bit 2 marks it conforming. S=0 with type 4 or C is a call gate, type 5 is a task gate, and type 1 or 9 is an available TSS. Anything else, including data segments and busy TSS types, faults with vector 13 and the selector.
- R6: A conforming code target needs DPL <= CPL, else vector 13 with the selector.
- R7: A non-conforming code target needs RPL <= CPL and DPL == CPL, else vector 13 with the selector.
- R8: A descriptor that passes its privilege checks but has the present bit clear faults with vector 11 and that descriptor's selector.
- R9: The code limit is the 20-bit limit, or that limit shifted left by 12 with the low bits set when granularity is 1. An offset above it faults with vector 13 and error code 0. With `op32_i` low, only the low 16 bits of the offset are used, zero-extended.
- R10: A successful code jump gives result 0, the target selector with RPL replaced by CPL on `cs_sel_o`, and the offset on `eip_o`. The other result fields are zero.
- R11: A call gate needs DPL >= CPL and DPL >= RPL, and the gate must be present. Its target selector is then checked in this order: null (error 0), table limit, code kind, then the conforming or non-conforming DPL rule, presence and offset limit. The offset comes from the gate. Faults on the target report the target selector.
- R12: A task gate passes the same gate checks. Its TSS selector must have table bit 0, lie within the global limit, and name a present available TSS. Otherwise it faults with the TSS selector. On success the result is 1 with the TSS selector on `ts_sel_o`.
- R13: A direct TSS target needs DPL >= CPL, DPL >= RPL and presence. On success the result is 1 with the original selector on `ts_sel_o`.
- R14: Checks run in the order listed, and the first failure decides the fault. Privilege failures take precedence over absence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check, taken while idle |
| sel_i | input | 16 | Destination selector |
| off_i | input | 32 | Destination offset from the pointer |
| op32_i | input | 1 | 1 = 32-bit operand size |
| cpl_i | input | 2 | Current privilege level |
| gdt_lim_i | input | 16 | Global table byte limit |
| ldt_lim_i | input | 16 | Local table byte limit |
| rd_req_o | output | 1 | Descriptor read request |
| rd_sel_o | output | 16 | Selector whose descriptor is wanted |
| rd_ack_i | input | 1 | Descriptor valid this cycle |
| rd_desc_i | input | 64 | Descriptor contents |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Walk in progress |
| res_o | output | 2 | 0 code load, 1 task switch, 2 fault |
| cs_sel_o | output | 16 | New code selector |
| eip_o | output | 32 | New instruction offset |
| ts_sel_o | output | 16 | Task-state selector to switch to |
| vec_o | output | 8 | Fault vector (13 or 11) |
| err_o | output | 16 | Fault error code |

## Verification
A wrong walk state shows on the read port first. It appears as a missing or extra descriptor read, or a second read aimed at the wrong selector, within one cycle of the acknowledge that should have led to it. A wrong kind, privilege comparison or stored gate field shows only at the `done_o` pulse, as a wrong result code, vector or error code. A selector latched with the wrong RPL shows there too, as a wrong `cs_sel_o`. Counting reads per request therefore separates early faults, which use no read, from late faults on the second descriptor.

// File: rtl/fj_pkg.sv
package fj_pkg;
    typedef enum logic [2:0] {K_BAD, K_CONF, K_NCONF, K_CGATE, K_TGATE, K_TSS} kind_e;
    typedef enum logic [1:0] {RES_LOAD = 2'd0, RES_TASK = 2'd1, RES_FAULT = 2'd2} res_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RD1, ST_RD2} st_e;
    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_NP = 8'd11;
endpackage

// File: rtl/fj_sel_check.sv
module fj_sel_check #(
    parameter int LIM_W = 16
) (
    input  logic [15:0]      sel_i,
    input  logic [LIM_W-1:0] gdt_lim_i,
    input  logic [LIM_W-1:0] ldt_lim_i,
    output logic             null_o,
    output logic             over_o
);
    logic [LIM_W-1:0] lim;
    logic [31:0]      last_byte;
    logic [1:0]       unused_rpl;

    assign unused_rpl = sel_i[1:0];
    assign lim        = sel_i[2] ? ldt_lim_i : gdt_lim_i;
    assign last_byte  = 32'({sel_i[15:3], 3'b111});
    assign null_o     = (sel_i[15:2] == 14'd0);
    assign over_o     = last_byte > 32'(lim);
endmodule

// File: rtl/fj_desc_decode.sv
module fj_desc_decode
    import fj_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic [63:0]      desc_i,
    input  logic [OFF_W-1:0] off_i,
    output kind_e            kind_o,
    output logic [1:0]       dpl_o,
    output logic             present_o,
    output logic             off_ok_o,
    output logic [15:0]      tgt_sel_o,
    output logic [31:0]      tgt_off_o
);
    logic        s_bit;
    logic [3:0]  typ;
    logic [19:0] raw_lim;
    logic [31:0] eff_lim;
    logic [10:0] unused_bits;

    assign unused_bits = {desc_i[39:32], desc_i[54:52]};
    assign s_bit       = desc_i[44];
    assign typ         = desc_i[43:40];
    assign dpl_o       = desc_i[46:45];
    assign present_o   = desc_i[47];
    assign raw_lim     = {desc_i[51:48], desc_i[15:0]};
    assign eff_lim     = desc_i[55] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
    assign off_ok_o    = 32'(off_i) <= eff_lim;
    assign tgt_sel_o   = desc_i[31:16];
    assign tgt_off_o   = {desc_i[63:48], desc_i[15:0]};

    always_comb begin
        kind_o = K_BAD;
        if (s_bit) begin
            if (typ[3]) kind_o = typ[2] ? K_CONF : K_NCONF;
        end else begin
            unique case (typ)
                4'h4, 4'hC: kind_o = K_CGATE;
                4'h5:       kind_o = K_TGATE;
                4'h1, 4'h9: kind_o = K_TSS;
                default:    kind_o = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/farjmp_guard.sv
module farjmp_guard
    import fj_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      sel_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             op32_i,
    input  logic [1:0]       cpl_i,
    input  logic [LIM_W-1:0] gdt_lim_i,
    input  logic [LIM_W-1:0] ldt_lim_i,
    output logic             rd_req_o,
    output logic [15:0]      rd_sel_o,
    input  logic             rd_ack_i,
    input  logic [63:0]      rd_desc_i,
    output logic             done_o,
    output logic             busy_o,
    output logic [1:0]       res_o,
    output logic [15:0]      cs_sel_o,
    output logic [OFF_W-1:0] eip_o,
    output logic [15:0]      ts_sel_o,
    output logic [7:0]       vec_o,
    output logic [15:0]      err_o
);
    localparam int HALF_W = OFF_W / 2;

    typedef struct packed {
        st_e              st;
        logic [15:0]      sel;
        logic [15:0]      rsel;
        logic [OFF_W-1:0] off;
        logic             op32;
        logic [1:0]       cpl;
        logic [LIM_W-1:0] glim;
        logic [LIM_W-1:0] llim;
        kind_e            gkind;
        logic             done;
        res_e             res;
        logic [15:0]      cs;
        logic [OFF_W-1:0] eip;
        logic [15:0]      ts;
        logic [7:0]       vec;
        logic [15:0]      err;
    } walk_t;

    walk_t q, n;

    logic a_null, a_over, b_null, b_over;
    kind_e d_kind;
    logic [1:0] d_dpl;
    logic d_p, d_ok;
    logic [15:0] d_tsel;
    logic [31:0] d_toff;

    logic fin;
    res_e f_res;
    logic [7:0] f_vec;
    logic [15:0] f_err, f_cs, f_ts;
    logic [OFF_W-1:0] f_eip;
    logic [15:0] e_sel, r_sel, t_sel;
    logic code_priv_bad, gate_priv_bad, tgt_bad;

    // selector screening before any read: request selector and gate target
    fj_sel_check #(.LIM_W(LIM_W)) u_chk_a (
        .sel_i(sel_i), .gdt_lim_i(gdt_lim_i), .ldt_lim_i(ldt_lim_i),
        .null_o(a_null), .over_o(a_over)
    );
    fj_sel_check #(.LIM_W(LIM_W)) u_chk_b (
        .sel_i(d_tsel), .gdt_lim_i(q.glim), .ldt_lim_i(q.llim),
        .null_o(b_null), .over_o(b_over)
    );
    fj_desc_decode #(.OFF_W(OFF_W)) u_dec (
        .desc_i(rd_desc_i), .off_i(q.off), .kind_o(d_kind), .dpl_o(d_dpl),
        .present_o(d_p), .off_ok_o(d_ok), .tgt_sel_o(d_tsel), .tgt_off_o(d_toff)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        fin    = 1'b0;
        f_res  = RES_FAULT;
        f_vec  = VEC_GP;
        f_err  = '0;
        f_cs   = '0;
        f_eip  = '0;
        f_ts   = '0;
        e_sel  = {q.sel[15:2], 2'b00};
        r_sel  = {q.rsel[15:2], 2'b00};
        t_sel  = {d_tsel[15:2], 2'b00};
        gate_priv_bad = (d_dpl < q.cpl) || (d_dpl < q.sel[1:0]);
        code_priv_bad = (d_kind == K_CONF) ? (d_dpl > q.cpl)
                      : ((q.sel[1:0] > q.cpl) || (d_dpl != q.cpl));
        tgt_bad = !((d_kind == K_CONF) || (d_kind == K_NCONF))
                || ((d_kind == K_CONF) ? (d_dpl > q.cpl) : (d_dpl != q.cpl));

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.sel  = sel_i;
                    n.rsel = sel_i;
                    n.cpl  = cpl_i;
                    n.op32 = op32_i;
                    n.off  = op32_i ? off_i : {{HALF_W{1'b0}}, off_i[HALF_W-1:0]};
                    n.glim = gdt_lim_i;
                    n.llim = ldt_lim_i;
                    fin    = a_null || a_over;
                    f_err  = a_null ? 16'h0 : {sel_i[15:2], 2'b00};
                    if (!fin) n.st = ST_RD1;
                end
            end
            ST_RD1: begin
                if (rd_ack_i) begin
                    fin = 1'b1;
                    unique case (d_kind)
                        K_CONF, K_NCONF: begin
                            if (code_priv_bad)  f_err = e_sel;
                            else if (!d_p) begin f_vec = VEC_NP; f_err = e_sel; end
                            else if (!d_ok)     f_err = '0;
                            else begin
                                f_res = RES_LOAD;
                                f_cs  = {q.sel[15:2], q.cpl};
                                f_eip = q.off;
                            end
                        end
                        K_CGATE, K_TGATE: begin
                            if (gate_priv_bad)  f_err = e_sel;
                            else if (!d_p) begin f_vec = VEC_NP; f_err = e_sel; end
                            else if (d_kind == K_CGATE && b_null) f_err = '0;
                            else if (d_kind == K_TGATE && d_tsel[2]) f_err = t_sel;
                            else if (b_over)    f_err = t_sel;
                            else begin
                                fin     = 1'b0;
                                n.st    = ST_RD2;
                                n.rsel  = d_tsel;
                                n.gkind = d_kind;
                                if (d_kind == K_CGATE)
                                    n.off = q.op32 ? OFF_W'(d_toff)
                                                   : {{HALF_W{1'b0}}, d_toff[HALF_W-1:0]};
                            end
                        end
                        K_TSS: begin
                            if (gate_priv_bad)  f_err = e_sel;
                            else if (!d_p) begin f_vec = VEC_NP; f_err = e_sel; end
                            else begin f_res = RES_TASK; f_ts = q.sel; end
                        end
                        default: f_err = e_sel;
                    endcase
                end
            end
            ST_RD2: begin
                if (rd_ack_i) begin
                    fin = 1'b1;
                    if (q.gkind == K_CGATE) begin
                        if (tgt_bad)        f_err = r_sel;
                        else if (!d_p) begin f_vec = VEC_NP; f_err = r_sel; end
                        else if (!d_ok)     f_err = '0;
                        else begin
                            f_res = RES_LOAD;
                            f_cs  = {q.rsel[15:2], q.cpl};
                            f_eip = q.off;
                        end
                    end else begin
                        if (d_kind != K_TSS) f_err = r_sel;
                        else if (!d_p) begin f_vec = VEC_NP; f_err = r_sel; end
                        else begin f_res = RES_TASK; f_ts = q.rsel; end
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        if (fin) begin
            n.st   = ST_IDLE;
            n.done = 1'b1;
            n.res  = f_res;
            n.cs   = f_cs;
            n.eip  = f_eip;
            n.ts   = f_ts;
            n.vec  = (f_res == RES_FAULT) ? f_vec : 8'h0;
            n.err  = (f_res == RES_FAULT) ? f_err : 16'h0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.gkind <= K_BAD;
            q.res   <= RES_LOAD;
        end else begin
            q <= n;
        end
    end

    assign rd_req_o = (q.st != ST_IDLE);
    assign busy_o   = (q.st != ST_IDLE);
    assign rd_sel_o = q.rsel;
    assign done_o   = q.done;
    assign res_o    = q.res;
    assign cs_sel_o = q.cs;
    assign eip_o    = q.eip;
    assign ts_sel_o = q.ts;
    assign vec_o    = q.vec;
    assign err_o    = q.err;

    // R4: a pending read keeps its request and selector until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_sel_o));
    // R4: completion pulse lasts one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2: a null selector finishes without issuing a read
    assert_null_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (sel_i[15:2] == 14'd0) |=> done_o && !rd_req_o);
    // R10: a code load never yields a null selector
    assert_load_nonnull_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && res_o == RES_LOAD |-> cs_sel_o[15:2] != 14'd0);
    // R9: short operand size never produces a wide offset
    assert_short_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && res_o == RES_LOAD && !q.op32 |-> eip_o[OFF_W-1:HALF_W] == '0);
    // R8: every fault carries one of the two vectors
    assert_fault_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && res_o == RES_FAULT |-> (vec_o == VEC_GP) || (vec_o == VEC_NP));
endmodule

// File: tb/farjmp_guard_tb.sv
module farjmp_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] sel = '0;
    logic [31:0] off = '0;
    logic op32 = 1'b1;
    logic [1:0] cpl = '0;
    logic [15:0] gdt_lim = 16'd127;
    logic [15:0] ldt_lim = 16'd31;
    logic rd_req, rd_ack, done, busy;
    logic [15:0] rd_sel, cs_sel, ts_sel, err;
    logic [63:0] rd_desc;
    logic [1:0] res;
    logic [31:0] eip;
    logic [7:0] vec;

    logic [63:0] gdt [16];
    logic [63:0] ldt [16];
    int total = 0;
    int bad = 0;
    int reads = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    farjmp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sel_i(sel), .off_i(off),
        .op32_i(op32), .cpl_i(cpl), .gdt_lim_i(gdt_lim), .ldt_lim_i(ldt_lim),
        .rd_req_o(rd_req), .rd_sel_o(rd_sel), .rd_ack_i(rd_ack), .rd_desc_i(rd_desc),
        .done_o(done), .busy_o(busy), .res_o(res), .cs_sel_o(cs_sel), .eip_o(eip),
        .ts_sel_o(ts_sel), .vec_o(vec), .err_o(err)
    );

    // descriptor memory: answers one cycle after a request is seen
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_desc <= '0;
        end else begin
            if (rd_req && rd_ack) reads <= reads + 1;
            rd_ack  <= rd_req && !rd_ack;
            rd_desc <= rd_sel[2] ? ldt[rd_sel[6:3]] : gdt[rd_sel[6:3]];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [63:0] mk_code(bit conf, logic [1:0] dpl, bit p, bit g, logic [19:0] lim);
        return {8'h00, g, 1'b1, 2'b00, lim[19:16], p, dpl, 1'b1, conf ? 4'hE : 4'hA, 24'h0, lim[15:0]};
    endfunction
    function automatic logic [63:0] mk_gate(logic [3:0] typ, logic [1:0] dpl, bit p, logic [15:0] s, logic [31:0] o);
        return {o[31:16], p, dpl, 1'b0, typ, 8'h00, s, o[15:0]};
    endfunction
    function automatic logic [63:0] mk_tss(logic [3:0] typ, logic [1:0] dpl, bit p);
        return {8'h00, 4'h0, 4'h0, p, dpl, 1'b0, typ, 24'h0, 16'h0067};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic go(input logic [15:0] s, input logic [31:0] o, input logic w, input logic [1:0] c);
        int k;
        @(negedge clk);
        sel = s; off = o; op32 = w; cpl = c; start = 1'b1; reads = 0;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (!done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL no completion for selector %h", s);
        end
    endtask

    task automatic expect_load(input string tag, input logic [15:0] cs, input logic [31:0] ip, input int rd);
        chk({tag, " res"}, 32'(res), 32'd0);
        chk({tag, " cs"}, 32'(cs_sel), 32'(cs));
        chk({tag, " eip"}, eip, ip);
        chk({tag, " ts"}, 32'(ts_sel), 32'd0);
        chk({tag, " err"}, 32'(err), 32'd0);
        chk({tag, " reads"}, 32'(reads), 32'(rd));
    endtask
    task automatic expect_task(input string tag, input logic [15:0] ts, input int rd);
        chk({tag, " res"}, 32'(res), 32'd1);
        chk({tag, " ts"}, 32'(ts_sel), 32'(ts));
        chk({tag, " cs"}, 32'(cs_sel), 32'd0);
        chk({tag, " reads"}, 32'(reads), 32'(rd));
    endtask
    task automatic expect_fault(input string tag, input logic [7:0] v, input logic [15:0] e, input int rd);
        chk({tag, " res"}, 32'(res), 32'd2);
        chk({tag, " vec"}, 32'(vec), 32'(v));
        chk({tag, " err"}, 32'(err), 32'(e));
        chk({tag, " cs"}, 32'(cs_sel), 32'd0);
        chk({tag, " reads"}, 32'(reads), 32'(rd));
    endtask

    task automatic t_reset;
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 req", 32'(rd_req), 32'd0);
    endtask

    task automatic t_null;
        go(16'h0003, 32'h10, 1'b1, 2'd3);
        expect_fault("R2 null", 8'd13, 16'h0, 0);
        @(negedge clk);
        chk("R4 done pulse", 32'(done), 32'd0);
    endtask

    task automatic t_table_lim;
        go(16'h0083, 32'h0, 1'b1, 2'd3);
        expect_fault("R3 gdt over", 8'd13, 16'h0080, 0);
        go(16'h0027, 32'h0, 1'b1, 2'd3);
        expect_fault("R3 ldt over", 8'd13, 16'h0024, 0);
    endtask

    task automatic t_conforming;
        go(16'h000B, 32'h1234, 1'b1, 2'd2);
        expect_load("R6 R10 conf ok", 16'h000A, 32'h1234, 1);
        go(16'h0008, 32'h1234, 1'b1, 2'd0);
        expect_fault("R6 conf dpl", 8'd13, 16'h0008, 1);
        go(16'h0004, 32'h5, 1'b1, 2'd1);
        expect_load("R10 ldt conf", 16'h0005, 32'h5, 1);
    endtask

    task automatic t_nonconf;
        go(16'h0012, 32'h0FFF, 1'b1, 2'd2);
        expect_load("R7 nconf ok", 16'h0012, 32'h0FFF, 1);
        go(16'h0013, 32'h0, 1'b1, 2'd2);
        expect_fault("R7 rpl", 8'd13, 16'h0010, 1);
        go(16'h0013, 32'h0, 1'b1, 2'd3);
        expect_fault("R7 dpl ne", 8'd13, 16'h0010, 1);
    endtask

    task automatic t_present_order;
        go(16'h001A, 32'h0, 1'b1, 2'd2);
        expect_fault("R8 absent", 8'd11, 16'h0018, 1);
        go(16'h001B, 32'h0, 1'b1, 2'd3);
        expect_fault("R14 priv before absent", 8'd13, 16'h0018, 1);
    endtask

    task automatic t_offset;
        go(16'h0012, 32'h1001, 1'b1, 2'd2);
        expect_fault("R9 over", 8'd13, 16'h0, 1);
        go(16'h0048, 32'h1FFF, 1'b1, 2'd0);
        expect_load("R9 gran", 16'h0048, 32'h1FFF, 1);
        go(16'h0048, 32'h2000, 1'b1, 2'd0);
        expect_fault("R9 gran over", 8'd13, 16'h0, 1);
        go(16'h0012, 32'hABCD0800, 1'b0, 2'd2);
        expect_load("R9 short", 16'h0012, 32'h0800, 1);
        go(16'h0012, 32'hABCD0800, 1'b1, 2'd2);
        expect_fault("R9 wide", 8'd13, 16'h0, 1);
    endtask

    task automatic t_kinds;
        go(16'h0030, 32'h0, 1'b1, 2'd0);
        expect_fault("R5 data", 8'd13, 16'h0030, 1);
        go(16'h0043, 32'h0, 1'b1, 2'd3);
        expect_fault("R5 busy tss", 8'd13, 16'h0040, 1);
    endtask

    task automatic t_callgate;
        go(16'h0022, 32'hFFFF_FFFF, 1'b0, 2'd2);
        expect_load("R11 gate ok", 16'h0012, 32'h0800, 2);
        go(16'h0022, 32'h0, 1'b1, 2'd2);
        expect_fault("R11 gate wide off", 8'd13, 16'h0, 2);
        go(16'h0023, 32'h0, 1'b1, 2'd3);
        expect_fault("R11 target dpl", 8'd13, 16'h0010, 2);
        go(16'h0052, 32'h0, 1'b1, 2'd2);
        expect_fault("R11 gate dpl cpl", 8'd13, 16'h0050, 1);
        go(16'h0053, 32'h0, 1'b1, 2'd1);
        expect_fault("R11 gate dpl rpl", 8'd13, 16'h0050, 1);
        go(16'h005B, 32'h0, 1'b1, 2'd3);
        expect_fault("R8 gate absent", 8'd11, 16'h0058, 1);
        go(16'h0062, 32'h0, 1'b1, 2'd2);
        expect_fault("R8 target absent", 8'd11, 16'h0018, 2);
        go(16'h0014, 32'h0, 1'b1, 2'd3);
        expect_fault("R11 null target", 8'd13, 16'h0, 1);
        go(16'h001C, 32'h0, 1'b1, 2'd3);
        expect_fault("R11 data target", 8'd13, 16'h0030, 2);
        go(16'h007B, 32'h0, 1'b1, 2'd3);
        expect_fault("R11 target over", 8'd13, 16'h0408, 1);
    endtask

    task automatic t_taskgate;
        go(16'h002B, 32'h0, 1'b1, 2'd3);
        expect_task("R12 task gate", 16'h0038, 2);
        go(16'h006B, 32'h0, 1'b1, 2'd3);
        expect_fault("R12 busy target", 8'd13, 16'h0040, 2);
        go(16'h000F, 32'h0, 1'b1, 2'd3);
        expect_fault("R12 local tss", 8'd13, 16'h000C, 1);
    endtask

    task automatic t_tss;
        go(16'h003B, 32'h0, 1'b1, 2'd3);
        expect_task("R13 direct", 16'h003B, 1);
        go(16'h0073, 32'h0, 1'b1, 2'd3);
        expect_fault("R13 dpl", 8'd13, 16'h0070, 1);
    endtask

    initial begin
        foreach (gdt[i]) gdt[i] = '0;
        foreach (ldt[i]) ldt[i] = '0;
        gdt[1]  = mk_code(1'b1, 2'd1, 1'b1, 1'b0, 20'h0FFFF);
        gdt[2]  = mk_code(1'b0, 2'd2, 1'b1, 1'b0, 20'h01000);
        gdt[3]  = mk_code(1'b0, 2'd2, 1'b0, 1'b0, 20'h01000);
        gdt[4]  = mk_gate(4'hC, 2'd3, 1'b1, 16'h0010, 32'h0003_0800);
        gdt[5]  = mk_gate(4'h5, 2'd3, 1'b1, 16'h0038, 32'h0);
        gdt[6]  = {8'h00, 4'h4, 4'h0, 1'b1, 2'd0, 1'b1, 4'h2, 24'h0, 16'hFFFF};
        gdt[7]  = mk_tss(4'h9, 2'd3, 1'b1);
        gdt[8]  = mk_tss(4'hB, 2'd3, 1'b1);
        gdt[9]  = mk_code(1'b0, 2'd0, 1'b1, 1'b1, 20'h00001);
        gdt[10] = mk_gate(4'hC, 2'd1, 1'b1, 16'h0010, 32'h0);
        gdt[11] = mk_gate(4'hC, 2'd3, 1'b0, 16'h0010, 32'h0);
        gdt[12] = mk_gate(4'hC, 2'd3, 1'b1, 16'h0018, 32'h100);
        gdt[13] = mk_gate(4'h5, 2'd3, 1'b1, 16'h0040, 32'h0);
        gdt[14] = mk_tss(4'h1, 2'd0, 1'b1);
        gdt[15] = mk_gate(4'hC, 2'd3, 1'b1, 16'h0408, 32'h0);
        ldt[0]  = mk_code(1'b1, 2'd0, 1'b1, 1'b0, 20'h0FFFF);
        ldt[1]  = mk_gate(4'h5, 2'd3, 1'b1, 16'h000C, 32'h0);
        ldt[2]  = mk_gate(4'hC, 2'd3, 1'b1, 16'h0000, 32'h0);
        ldt[3]  = mk_gate(4'hC, 2'd3, 1'b1, 16'h0030, 32'h0);

        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_null();
        t_table_lim();
        t_conforming();
        t_nonconf();
        t_present_order();
        t_offset();
        t_kinds();
        t_callgate();
        t_taskgate();
        t_tss();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule